// File: doc/BRIEF.md
# Segmented Register Bus Decoder

This block turns one simple memory-mapped read/write port into accesses to a set of register-mapped cores. A 16-bit address is split three ways. The top bits pick a segment: hashing, random generation or ciphering. The middle bits pick a core slot within that segment. The low bits pick a register inside the core. The block drives a select, a write strobe, the register offset and the write data to each slot. It then multiplexes the slots' combinational read data into an output register, so a read always answers exactly one clock after it is requested.

Slot zero of the first segment is a small bank of board-level registers: a board type word, a bitstream version word and one read/write scratch word. Every other slot holds a stub core. Each stub has an identity word and one scratch register. A per-slot enable parameter decides which slots are built. A slot that is not built answers like empty address space: reads return zero and writes vanish. The block has no error output.

Top module: `seg_bus_decoder`

## Requirements
- R1: Read data is registered. `bus_rdata` changes only at the clock edge where `bus_rd` is high. It shows the addressed word from that edge on and holds its value while `bus_rd` is low.
- R2: A read of address 0x0000 (segment 0, core 0, offset 0) returns the `BOARD_TYPE` parameter.
- R3: A read of address 0x0001 returns the `BITSTREAM_VER` parameter.
- R4: Address 0x0002 is a 32-bit scratch register. It reads back the last value written to it.
- R5: Writes to 0x0000 and 0x0001 have no effect on the values read there.
- R6: The address is split as follows: bits [15:13] are the segment (0 hash, 1 random, 2 cipher), bits [12:8] the core, and bits [7:0] the offset. Each built stub core returns 0x00A5_SSCC at offset 0, where SS is the segment and CC is the core. Offset 1 of a stub is a read/write scratch register.
- R7: A read of an unmapped location returns zero. Unmapped locations are segments 3 to 7, cores 4 to 31, and unused offsets inside a core.
- R8: A write to an unmapped location changes no register anywhere. In particular, a core number above 3 does not alias onto cores 0 to 3.
- R9: A slot whose `SLOT_EN` bit (index segment*4+core) is 0 behaves exactly like an unmapped location. The default leaves slots 3 (segment 0 core 3) and 10 (segment 2 core 2) unbuilt.
- R10: At most one slot is selected per access, so a write to one stub leaves the scratch registers of the other stubs unchanged.
- R11: Reset clears `bus_rdata` and every scratch register to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 16 | Segment, core and offset address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |

## Verification
The hardest case to reach from the ports is a write that lands on unmapped space but could be decoded wrongly. Examples are a core number past the last slot whose low bits match a live slot, an unbuilt slot, or a segment past the third. A miss shows up only as a corrupted register elsewhere. The stimulus therefore first loads known patterns into the global and stub scratch registers. It then writes to each of these aliasing or unbuilt addresses, reads the address itself, and reads the scratch registers that a faulty decoder would have hit. The read latency is probed by sampling `bus_rdata` while a new read strobe is already applied but before its clock edge.

// File: rtl/seg_dec_pkg.sv
package seg_dec_pkg;

  localparam int DATA_W = 32;
  localparam int SEG_W  = 3;
  localparam int CORE_W = 5;
  localparam int OFS_W  = 8;
  localparam int ADDR_W = SEG_W + CORE_W + OFS_W;

  // upper half of every stub core identity word
  localparam logic [15:0] STUB_TAG = 16'h00A5;

  // global bank register offsets
  localparam logic [OFS_W-1:0] GB_OFS_BOARD   = 8'h00;
  localparam logic [OFS_W-1:0] GB_OFS_VERSION = 8'h01;
  localparam logic [OFS_W-1:0] GB_OFS_SCRATCH = 8'h02;

  // stub core register offsets
  localparam logic [OFS_W-1:0] STUB_OFS_ID      = 8'h00;
  localparam logic [OFS_W-1:0] STUB_OFS_SCRATCH = 8'h01;

  typedef logic [DATA_W-1:0] word_t;

  typedef struct packed {
    logic [SEG_W-1:0]  seg;
    logic [CORE_W-1:0] core;
    logic [OFS_W-1:0]  ofs;
  } bus_addr_t;

endpackage

// File: rtl/seg_addr_decode.sv
module seg_addr_decode
  import seg_dec_pkg::*;
#(
  parameter int N_SEG  = 3,
  parameter int N_CORE = 4,
  parameter logic [N_SEG*N_CORE-1:0] SLOT_EN = '1
) (
  input  bus_addr_t                 addr_f,
  output logic [N_SEG*N_CORE-1:0]   slot_sel
);

  localparam int N_SLOT = N_SEG * N_CORE;

  // one comparator pair per slot; unbuilt slots never decode
  for (genvar i = 0; i < N_SLOT; i++) begin : g_slot
    if (SLOT_EN[i]) begin : g_on
      always_comb begin
        slot_sel[i] = (addr_f.seg  == SEG_W'(i / N_CORE)) &&
                      (addr_f.core == CORE_W'(i % N_CORE));
      end
    end else begin : g_off
      always_comb slot_sel[i] = 1'b0;
    end
  end

endmodule

// File: rtl/seg_global_bank.sv
module seg_global_bank
  import seg_dec_pkg::*;
#(
  parameter logic [DATA_W-1:0] BOARD_TYPE    = 32'h0B0A_0001,
  parameter logic [DATA_W-1:0] BITSTREAM_VER = 32'h0002_0015
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs,
  input  logic              we,
  input  logic [OFS_W-1:0]  ofs,
  input  word_t             wdata,
  output word_t             rdata
);

  word_t scratch_q;
  word_t scratch_d;
  logic  scratch_en;

  // next-state: only the scratch word is writable
  always_comb begin
    scratch_en = cs && we && (ofs == GB_OFS_SCRATCH);
    scratch_d  = scratch_en ? wdata : scratch_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scratch_q <= '0;
    end else if (scratch_en) begin
      scratch_q <= scratch_d;
    end
  end

  // combinational read port, muxed and registered by the top
  always_comb begin
    unique case (ofs)
      GB_OFS_BOARD:   rdata = BOARD_TYPE;
      GB_OFS_VERSION: rdata = BITSTREAM_VER;
      GB_OFS_SCRATCH: rdata = scratch_q;
      default:        rdata = '0;
    endcase
  end

endmodule

// File: rtl/seg_stub_core.sv
module seg_stub_core
  import seg_dec_pkg::*;
#(
  parameter logic [DATA_W-1:0] ID_WORD = 32'h00A5_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs,
  input  logic              we,
  input  logic [OFS_W-1:0]  ofs,
  input  word_t             wdata,
  output word_t             rdata
);

  word_t scratch_q;
  word_t scratch_d;
  logic  scratch_en;

  always_comb begin
    scratch_en = cs && we && (ofs == STUB_OFS_SCRATCH);
    scratch_d  = scratch_en ? wdata : scratch_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scratch_q <= '0;
    end else if (scratch_en) begin
      scratch_q <= scratch_d;
    end
  end

  always_comb begin
    unique case (ofs)
      STUB_OFS_ID:      rdata = ID_WORD;
      STUB_OFS_SCRATCH: rdata = scratch_q;
      default:          rdata = '0;
    endcase
  end

endmodule

// File: rtl/seg_bus_decoder.sv
module seg_bus_decoder
  import seg_dec_pkg::*;
#(
  parameter int N_SEG  = 3,
  parameter int N_CORE = 4,
  parameter logic [DATA_W-1:0] BOARD_TYPE    = 32'h0B0A_0001,
  parameter logic [DATA_W-1:0] BITSTREAM_VER = 32'h0002_0015,
  parameter logic [N_SEG*N_CORE-1:0] SLOT_EN = 12'hBF7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata
);

  localparam int N_SLOT = N_SEG * N_CORE;

  bus_addr_t          addr_f;
  logic [N_SLOT-1:0]  slot_sel;
  word_t              slot_rdata [N_SLOT];
  word_t              mux_rdata;
  word_t              rdata_q;
  word_t              rdata_d;

  assign addr_f = bus_addr_t'(bus_addr);

  seg_addr_decode #(
    .N_SEG   (N_SEG),
    .N_CORE  (N_CORE),
    .SLOT_EN (SLOT_EN)
  ) dec_i (
    .addr_f   (addr_f),
    .slot_sel (slot_sel)
  );

  // slot 0 is the board bank, every other built slot a stub core
  for (genvar i = 0; i < N_SLOT; i++) begin : g_core
    if (!SLOT_EN[i]) begin : g_absent
      assign slot_rdata[i] = '0;
    end else if (i == 0) begin : g_board
      seg_global_bank #(
        .BOARD_TYPE    (BOARD_TYPE),
        .BITSTREAM_VER (BITSTREAM_VER)
      ) bank_i (
        .clk   (clk),
        .rst_n (rst_n),
        .cs    (slot_sel[i]),
        .we    (bus_wr),
        .ofs   (addr_f.ofs),
        .wdata (bus_wdata),
        .rdata (slot_rdata[i])
      );
    end else begin : g_stub
      seg_stub_core #(
        .ID_WORD ({STUB_TAG, 8'(i / N_CORE), 8'(i % N_CORE)})
      ) stub_i (
        .clk   (clk),
        .rst_n (rst_n),
        .cs    (slot_sel[i]),
        .we    (bus_wr),
        .ofs   (addr_f.ofs),
        .wdata (bus_wdata),
        .rdata (slot_rdata[i])
      );
    end
  end

  // AND-OR read mux: no select means all zeros
  always_comb begin
    mux_rdata = '0;
    for (int k = 0; k < N_SLOT; k++) begin
      mux_rdata = mux_rdata | (slot_rdata[k] & {DATA_W{slot_sel[k]}});
    end
  end

  // read-data register, enabled by the read strobe
  always_comb begin
    rdata_d = bus_rd ? mux_rdata : rdata_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (bus_rd) begin
      rdata_q <= rdata_d;
    end
  end

  assign bus_rdata = rdata_q;

endmodule

// File: rtl/seg_bus_decoder_chk.sv
module seg_bus_decoder_chk
  import seg_dec_pkg::*;
#(
  parameter int N_SEG  = 3,
  parameter int N_CORE = 4,
  parameter logic [DATA_W-1:0] BOARD_TYPE    = 32'h0B0A_0001,
  parameter logic [DATA_W-1:0] BITSTREAM_VER = 32'h0002_0015,
  parameter logic [N_SEG*N_CORE-1:0] SLOT_EN = 12'hBF7
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [ADDR_W-1:0]       bus_addr,
  input logic                    bus_rd,
  input logic [DATA_W-1:0]       bus_rdata,
  input logic [N_SEG*N_CORE-1:0] slot_sel
);

  logic slot_built;
  int   seg_i;
  int   core_i;

  // independent view of which addresses reach a built slot
  always_comb begin
    seg_i      = int'(bus_addr[ADDR_W-1 -: SEG_W]);
    core_i     = int'(bus_addr[OFS_W +: CORE_W]);
    slot_built = 1'b0;
    if (seg_i < N_SEG && core_i < N_CORE) begin
      slot_built = SLOT_EN[seg_i*N_CORE + core_i];
    end
  end

  // R10
  one_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(slot_sel));

  // R1
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata));

  // R7
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !slot_built) |=> (bus_rdata == '0));

  // R9
  unbuilt_no_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_built |-> (slot_sel == '0));

  // R2
  board_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == 16'h0000) |=> (bus_rdata == BOARD_TYPE));

  // R3
  version_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == 16'h0001) |=> (bus_rdata == BITSTREAM_VER));

endmodule

bind seg_bus_decoder seg_bus_decoder_chk #(
  .N_SEG         (N_SEG),
  .N_CORE        (N_CORE),
  .BOARD_TYPE    (BOARD_TYPE),
  .BITSTREAM_VER (BITSTREAM_VER),
  .SLOT_EN       (SLOT_EN)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_addr  (bus_addr),
  .bus_rd    (bus_rd),
  .bus_rdata (bus_rdata),
  .slot_sel  (slot_sel)
);

// File: tb/seg_bus_decoder_tb.sv
module seg_bus_decoder_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] BT = 32'h0B0A_0001;
  localparam logic [31:0] BV = 32'h0002_0015;

  // vector: {req[3:0], is_read, addr[15:0], data[31:0]}
  localparam int NV = 30;
  localparam logic [52:0] VEC [NV] = '{
    {4'd2,  1'b1, 16'h0000, BT},            // R2 board type
    {4'd3,  1'b1, 16'h0001, BV},            // R3 version
    {4'd4,  1'b1, 16'h0002, 32'h0},         // R4 scratch after reset
    {4'd4,  1'b0, 16'h0002, 32'hDEAD_BEEF},
    {4'd4,  1'b1, 16'h0002, 32'hDEAD_BEEF}, // R4 readback
    {4'd5,  1'b0, 16'h0000, 32'h1234_5678},
    {4'd5,  1'b1, 16'h0000, BT},            // R5 board type unchanged
    {4'd5,  1'b0, 16'h0001, 32'h8765_4321},
    {4'd5,  1'b1, 16'h0001, BV},            // R5 version unchanged
    {4'd6,  1'b1, 16'h0100, 32'h00A5_0001}, // R6 hash seg core1 id
    {4'd6,  1'b1, 16'h2000, 32'h00A5_0100}, // R6 random seg core0 id
    {4'd6,  1'b1, 16'h4000, 32'h00A5_0200}, // R6 cipher seg core0 id
    {4'd6,  1'b1, 16'h4300, 32'h00A5_0203}, // R6 cipher seg core3 id
    {4'd6,  1'b0, 16'h2001, 32'hCAFE_F00D},
    {4'd6,  1'b1, 16'h2001, 32'hCAFE_F00D}, // R6 stub scratch
    {4'd10, 1'b1, 16'h0101, 32'h0},         // R10 neighbour untouched
    {4'd10, 1'b1, 16'h4001, 32'h0},         // R10 same core, other seg
    {4'd9,  1'b1, 16'h0300, 32'h0},         // R9 unbuilt slot id
    {4'd9,  1'b0, 16'h0301, 32'h1111_1111},
    {4'd9,  1'b1, 16'h0301, 32'h0},         // R9 unbuilt write lost
    {4'd9,  1'b1, 16'h4200, 32'h0},         // R9 second unbuilt slot
    {4'd7,  1'b1, 16'h6000, 32'h0},         // R7 segment 3
    {4'd7,  1'b1, 16'hE0FF, 32'h0},         // R7 segment 7
    {4'd7,  1'b1, 16'h0003, 32'h0},         // R7 unused bank offset
    {4'd7,  1'b1, 16'h0105, 32'h0},         // R7 unused stub offset
    {4'd8,  1'b0, 16'h0402, 32'h5555_5555}, // core 4 aliases core 0?
    {4'd8,  1'b1, 16'h0402, 32'h0},         // R8
    {4'd8,  1'b1, 16'h0002, 32'hDEAD_BEEF}, // R8 bank scratch intact
    {4'd8,  1'b0, 16'h6001, 32'h7777_7777}, // segment 3 aliases seg 1?
    {4'd8,  1'b1, 16'h2001, 32'hCAFE_F00D}  // R8 stub scratch intact
  };

  logic        clk;
  logic        rst_n;
  logic [15:0] bus_addr;
  logic        bus_wr;
  logic        bus_rd;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;

  int n_checks;
  int n_fail;

  seg_bus_decoder #(
    .BOARD_TYPE    (BT),
    .BITSTREAM_VER (BV)
  ) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act,
                       input logic [31:0] exp, input string what);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic do_read(input logic [15:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    bus_rd   = 1'b1;
    @(negedge clk);
    bus_rd   = 1'b0;
    d        = bus_rdata;
  endtask

  task automatic do_write(input logic [15:0] a, input logic [31:0] w);
    @(negedge clk);
    bus_addr  = a;
    bus_wdata = w;
    bus_wr    = 1'b1;
    @(negedge clk);
    bus_wr    = 1'b0;
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures",
             n_checks, n_fail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
    $finish;
  end

  initial begin
    logic [31:0] d;
    n_checks  = 0;
    n_fail    = 0;
    rst_n     = 1'b0;
    bus_addr  = '0;
    bus_wr    = 1'b0;
    bus_rd    = 1'b0;
    bus_wdata = '0;
    repeat (3) @(negedge clk);
    check("R11", bus_rdata, 32'h0, "rdata in reset");
    rst_n = 1'b1;

    // table walk
    for (int k = 0; k < NV; k++) begin
      if (VEC[k][48]) begin
        do_read(VEC[k][47:32], d);
        check($sformatf("R%0d", VEC[k][52:49]), d, VEC[k][31:0],
              $sformatf("vector %0d addr %h", k, VEC[k][47:32]));
      end else begin
        do_write(VEC[k][47:32], VEC[k][31:0]);
      end
    end

    // R1: registered, one-cycle read and hold while idle
    do_read(16'h0000, d);
    repeat (3) @(negedge clk);
    check("R1", bus_rdata, BT, "hold while idle");
    bus_addr = 16'h0001;
    bus_rd   = 1'b1;
    #1;
    check("R1", bus_rdata, BT, "before edge");
    @(negedge clk);
    bus_rd = 1'b0;
    check("R1", bus_rdata, BV, "after one edge");
    bus_addr = 16'h0002;
    @(negedge clk);
    check("R1", bus_rdata, BV, "address change without strobe");

    // R11: reset mid-run clears scratch registers and read data
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R11", bus_rdata, 32'h0, "rdata after reset");
    rst_n = 1'b1;
    do_read(16'h0002, d);
    check("R11", d, 32'h0, "bank scratch after reset");
    do_read(16'h2001, d);
    check("R11", d, 32'h0, "stub scratch after reset");

    report();
    $finish;
  end

endmodule